// File: doc/BRIEF.md
# Streaming Gray-Level Histogram with Mean

The block counts 8-bit grayscale pixels into one counter per gray level (256 in all) while a frame streams in over a valid/ready handshake. A pixel flagged as the frame's final beat closes the frame. The block then plays the 256 counts out as a second valid/ready stream, one count per beat, starting at level 0 and ending at level 255. Each beat carries its gray level and a last-beat flag.

While the counts stream out, the block adds count times level into a running sum. After the final beat, a sequential divider divides that sum by the number of pixels that were counted. The quotient comes out as the frame's mean gray level, marked by a one-cycle strobe. The input is not ready while the readout and the division are in progress. A downstream stall therefore holds back the upstream pixel source.

An optional window mode counts only pixels whose level lies between a lower bound and an upper bound, both bounds included. The divisor is then the number of in-window pixels. Each counter is zeroed as its beat is accepted, so the next frame starts from an empty histogram with no separate clearing pass.

Top module: `gray_hist_mean`

## Requirements
- R1: After reset, pix_ready_o is 1, bin_valid_o is 0, mean_valid_o is 0, and every counter is zero.
- R2: Each accepted pixel that is counted adds one to the counter at its level. The readout presents levels 0,1,...,255 in order on bin_level_o, with the matching count on bin_count_o, and bin_last_o is 1 only at level 255.
- R3: In the cycle after the handshake of a pixel with pix_last_i = 1, bin_valid_o is 1 with level 0. pix_ready_o stays 0 from then until the cycle in which mean_valid_o is 1.
- R4: While bin_valid_o is 1 and bin_ready_i is 0, bin_valid_o, bin_level_o and bin_count_o keep their values in the next cycle.
- R5: When win_en_i is 1 at a pixel handshake, the pixel is counted only if win_lo_i <= level <= win_hi_i. When win_en_i is 0, every accepted pixel is counted.
- R6: Each counter reads zero after its beat is accepted, so counts from one frame never appear in the next.
- R7: mean_o equals floor(sum over levels of level*count / N), where N is the number of counted pixels. mean_o is 0 when N is 0.
- R8: mean_valid_o is a single-cycle pulse that arrives no later than 40 cycles after the last bin transfer. mean_o holds its value until the next pulse.
- R9: A final pixel that lies outside the window is not counted but still closes the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_en_i | input | 1 | Enables window counting |
| win_lo_i | input | 8 | Lower window bound, inclusive |
| win_hi_i | input | 8 | Upper window bound, inclusive |
| pix_valid_i | input | 1 | Pixel beat valid |
| pix_data_i | input | 8 | Pixel gray level |
| pix_last_i | input | 1 | Marks the frame's final pixel |
| pix_ready_o | output | 1 | Block accepts a pixel |
| bin_valid_o | output | 1 | Count beat valid |
| bin_count_o | output | 21 | Pixel count at the current level |
| bin_level_o | output | 8 | Gray level of the current beat |
| bin_last_o | output | 1 | Marks level 255 |
| bin_ready_i | input | 1 | Downstream accepts a count beat |
| mean_valid_o | output | 1 | One-cycle strobe for mean_o |
| mean_o | output | 8 | Mean gray level of the counted pixels |

## Verification
A counter that increments at the wrong level, or that is not zeroed on readout, shows up in the bin_count_o beat for that level during the same frame's readout or the next one. Because the bench compares every one of the 256 beats, the bad level is identified directly. A fault in the running sum or in the divider shows only in mean_o, about 30 cycles after the last beat. A wrong state in the sequencing shows within one cycle, as pix_ready_o or bin_valid_o at the wrong time, or as a level that moves while the readout is stalled.

// File: rtl/gh_pkg.sv
package gh_pkg;
  localparam int GH_PIX_W = 8;
  localparam int GH_CNT_W = 21;

  typedef enum logic [1:0] {
    GH_ACCUM = 2'd0,
    GH_READ  = 2'd1,
    GH_DIV   = 2'd2
  } gh_state_e;
endpackage

// File: rtl/gh_bins.sv
module gh_bins #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [PIX_W-1:0] inc_lvl_i,
  input  logic             rd_clr_i,
  input  logic [PIX_W-1:0] rd_lvl_i,
  output logic [CNT_W-1:0] rd_cnt_o
);
  localparam int NBINS = 1 << PIX_W;

  logic [CNT_W-1:0] bin_q [NBINS];

  for (genvar g = 0; g < NBINS; g++) begin : g_bin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bin_q[g] <= '0;
      end else if (rd_clr_i && rd_lvl_i == PIX_W'(g)) begin
        bin_q[g] <= '0;
      end else if (inc_i && inc_lvl_i == PIX_W'(g)) begin
        bin_q[g] <= bin_q[g] + 1'b1;
      end
    end
  end

  assign rd_cnt_o = bin_q[rd_lvl_i];

  AST_BIN_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> bin_q[inc_lvl_i] != '1); // R2
  AST_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i |=> bin_q[$past(rd_lvl_i)] == '0); // R6
  AST_NO_INC_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && rd_clr_i)); // R3
endmodule

// File: rtl/gh_divider.sv
module gh_divider #(
  parameter int N_W = 29,
  parameter int D_W = 21
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] dividend_i,
  input  logic [D_W-1:0] divisor_i,
  output logic           done_o,
  output logic [N_W-1:0] quot_o
);
  localparam int CW = $clog2(N_W + 1);

  logic [N_W-1:0] dvd_q;
  logic [D_W-1:0] rem_q;
  logic [CW-1:0]  cnt_q;
  logic           run_q;
  logic           done_q;
  logic [D_W:0]   trial;
  logic           take;

  assign trial = {rem_q, dvd_q[N_W-1]};
  assign take  = trial >= {1'b0, divisor_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        dvd_q <= dividend_i;
        rem_q <= '0;
        cnt_q <= CW'(N_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        // restoring step: one quotient bit per cycle
        if (take) rem_q <= D_W'(trial - {1'b0, divisor_i});
        else      rem_q <= trial[D_W-1:0];
        dvd_q <= {dvd_q[N_W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = dvd_q;

  AST_DIV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DIV_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !start_i); // R3
endmodule

// File: rtl/gray_hist_mean.sv
module gray_hist_mean
  import gh_pkg::*;
#(
  parameter int PIX_W = GH_PIX_W,
  parameter int CNT_W = GH_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_en_i,
  input  logic [PIX_W-1:0] win_lo_i,
  input  logic [PIX_W-1:0] win_hi_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_last_i,
  output logic             pix_ready_o,
  output logic             bin_valid_o,
  output logic [CNT_W-1:0] bin_count_o,
  output logic [PIX_W-1:0] bin_level_o,
  output logic             bin_last_o,
  input  logic             bin_ready_i,
  output logic             mean_valid_o,
  output logic [PIX_W-1:0] mean_o
);
  localparam int SUM_W = CNT_W + PIX_W;

  gh_state_e        state_q;
  logic [PIX_W-1:0] lvl_q;
  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] npix_q;
  logic [PIX_W-1:0] mean_q;
  logic             mean_vld_q;

  logic             pix_fire, in_win, hit, bin_fire, last_bin;
  logic [CNT_W-1:0] rd_cnt;
  logic [SUM_W-1:0] prod, sum_next, quot;
  logic             div_done;

  assign pix_ready_o = state_q == GH_ACCUM;
  assign pix_fire    = pix_valid_i & pix_ready_o;
  assign in_win      = !win_en_i || (pix_data_i >= win_lo_i && pix_data_i <= win_hi_i);
  assign hit         = pix_fire & in_win;

  assign bin_valid_o = state_q == GH_READ;
  assign bin_fire    = bin_valid_o & bin_ready_i;
  assign last_bin    = &lvl_q;
  assign prod        = SUM_W'(rd_cnt) * SUM_W'(lvl_q);
  assign sum_next    = sum_q + prod;

  gh_bins #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_bins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (hit),
    .inc_lvl_i (pix_data_i),
    .rd_clr_i  (bin_fire),
    .rd_lvl_i  (lvl_q),
    .rd_cnt_o  (rd_cnt)
  );

  gh_divider #(.N_W(SUM_W), .D_W(CNT_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (bin_fire & last_bin),
    .dividend_i (sum_next),
    .divisor_i  (npix_q),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= GH_ACCUM;
      lvl_q      <= '0;
      sum_q      <= '0;
      npix_q     <= '0;
      mean_q     <= '0;
      mean_vld_q <= 1'b0;
    end else begin
      mean_vld_q <= 1'b0;
      unique case (state_q)
        GH_ACCUM: begin
          if (hit) npix_q <= npix_q + 1'b1;
          if (pix_fire && pix_last_i) begin
            state_q <= GH_READ;
            lvl_q   <= '0;
          end
        end
        GH_READ: begin
          if (bin_fire) begin
            sum_q <= sum_next;
            lvl_q <= lvl_q + 1'b1;
            if (last_bin) state_q <= GH_DIV;
          end
        end
        GH_DIV: begin
          if (div_done) begin
            // empty frame: report zero instead of the all-ones quotient
            mean_q     <= (npix_q == '0) ? '0 : quot[PIX_W-1:0];
            mean_vld_q <= 1'b1;
            npix_q     <= '0;
            sum_q      <= '0;
            state_q    <= GH_ACCUM;
          end
        end
        default: state_q <= GH_ACCUM;
      endcase
    end
  end

  assign bin_count_o  = rd_cnt;
  assign bin_level_o  = lvl_q;
  assign bin_last_o   = bin_valid_o & last_bin;
  assign mean_valid_o = mean_vld_q;
  assign mean_o       = mean_q;

  AST_LAST_STARTS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_fire && pix_last_i) |=> (bin_valid_o && bin_level_o == '0)); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_valid_o && !bin_ready_i) |=>
      (bin_valid_o && $stable(bin_level_o) && $stable(bin_count_o))); // R4
  AST_LEVEL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_fire && !bin_last_o) |=>
      (bin_valid_o && bin_level_o == PIX_W'($past(bin_level_o) + 1'b1))); // R2
  AST_MEAN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mean_valid_o |=> !mean_valid_o); // R8
  AST_MEAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mean_valid_o |-> $stable(mean_o)); // R8
  AST_EMPTY_MEAN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_done && npix_q == '0) |=> (mean_valid_o && mean_o == '0)); // R7
endmodule

// File: tb/sim_gray_hist_mean.sv
module sim_gray_hist_mean;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en = 1'b0;
  logic [7:0]  win_lo = '0, win_hi = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        pix_last = 1'b0;
  logic        pix_ready;
  logic        bin_valid;
  logic [20:0] bin_count;
  logic [7:0]  bin_level;
  logic        bin_last;
  logic        bin_ready = 1'b0;
  logic        mean_valid;
  logic [7:0]  mean;

  int checks = 0, failures = 0, cycles = 0;
  int exp_bin[256];
  longint exp_sum = 0;
  int exp_n = 0;
  int px_q[$];
  string bin_req = "R2";

  always #(CLK_PERIOD / 2) clk = ~clk;

  gray_hist_mean u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .win_en_i(win_en), .win_lo_i(win_lo), .win_hi_i(win_hi),
    .pix_valid_i(pix_valid), .pix_data_i(pix_data), .pix_last_i(pix_last),
    .pix_ready_o(pix_ready),
    .bin_valid_o(bin_valid), .bin_count_o(bin_count), .bin_level_o(bin_level),
    .bin_last_o(bin_last), .bin_ready_i(bin_ready),
    .mean_valid_o(mean_valid), .mean_o(mean)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<%0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // drive px_q into the block; model counts with window rule
  task automatic send_frame();
    int early_bin = 0;
    for (int i = 0; i < px_q.size(); i++) begin
      int gap = ($urandom % 3 == 0) ? 1 : 0;
      for (int k = 0; k < gap; k++) begin
        @(negedge clk);
        pix_valid = 1'b0;
      end
      @(negedge clk);
      if (bin_valid) early_bin++;
      pix_valid = 1'b1;
      pix_data  = 8'(px_q[i]);
      pix_last  = (i == px_q.size() - 1);
      while (!pix_ready) @(negedge clk);
      if (!win_en || (px_q[i] >= int'(win_lo) && px_q[i] <= int'(win_hi))) begin
        exp_bin[px_q[i]]++;
        exp_sum += longint'(px_q[i]);
        exp_n++;
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_last  = 1'b0;
    chk(early_bin == 0, "R3", "bin_valid before frame end", early_bin, 0);
  endtask

  task automatic read_frame(input string start_req);
    int lvl = 0;
    int ready_bad = 0, hold_bad = 0, k = 0;
    bit stalled = 1'b0;
    int prev_lvl = 0, prev_cnt = 0;
    chk(bin_valid && bin_level == 8'd0, start_req, "readout start level",
        bin_level, 0);
    while (lvl < 256 && k < 5000) begin
      k++;
      if (pix_ready) ready_bad++;
      if (bin_valid) begin
        if (stalled && (int'(bin_level) != prev_lvl || int'(bin_count) != prev_cnt))
          hold_bad++;
        bin_ready = ($urandom % 4) != 0;
        if (bin_ready) begin
          chk(int'(bin_level) == lvl, "R2", "bin level", bin_level, lvl);
          chk(int'(bin_count) == exp_bin[lvl], bin_req, "bin count",
              bin_count, exp_bin[lvl]);
          chk(bin_last == (lvl == 255), "R2", "bin last", bin_last, lvl == 255);
          exp_sum += longint'(lvl) * 0;
          lvl++;
          stalled = 1'b0;
        end else begin
          stalled  = 1'b1;
          prev_lvl = int'(bin_level);
          prev_cnt = int'(bin_count);
        end
      end else begin
        bin_ready = 1'b0;
      end
      @(negedge clk);
    end
    bin_ready = 1'b0;
    chk(lvl == 256, "R2", "beats transferred", lvl, 256);
    chk(hold_bad == 0, "R4", "beat changed under stall", hold_bad, 0);
    k = 0;
    while (!mean_valid && k < 40) begin
      if (pix_ready) ready_bad++;
      @(negedge clk);
      k++;
    end
    chk(ready_bad == 0, "R3", "pix_ready during readout", ready_bad, 0);
    chk(mean_valid, "R8", "mean strobe latency", k, 40);
    begin
      longint em = (exp_n == 0) ? 0 : exp_sum / longint'(exp_n);
      chk(longint'(mean) == em, "R7", "mean value", mean, em);
      chk(pix_ready, "R3", "pix_ready at mean strobe", pix_ready, 1);
      @(negedge clk);
      chk(!mean_valid, "R8", "mean strobe width", mean_valid, 0);
      chk(longint'(mean) == em, "R8", "mean held", mean, em);
    end
    foreach (exp_bin[i]) exp_bin[i] = 0;
    exp_sum = 0;
    exp_n   = 0;
  endtask

  initial begin
    foreach (exp_bin[i]) exp_bin[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_ready && !bin_valid && !mean_valid, "R1", "reset outputs",
        {pix_ready, bin_valid, mean_valid}, 3'b100);

    // frame A: random levels, all counted
    px_q.delete();
    for (int i = 0; i < 300; i++) px_q.push_back(int'($urandom % 256));
    bin_req = "R2";
    send_frame();
    read_frame("R3");

    // frame B: saturating level; stale counts from A must be gone
    px_q.delete();
    for (int i = 0; i < 100; i++) px_q.push_back(255);
    bin_req = "R6";
    send_frame();
    read_frame("R3");

    // frame C: window 50..100 with boundary levels
    win_en = 1'b1; win_lo = 8'd50; win_hi = 8'd100;
    px_q.delete();
    px_q.push_back(50); px_q.push_back(100); px_q.push_back(49);
    px_q.push_back(101); px_q.push_back(0); px_q.push_back(255);
    for (int i = 0; i < 200; i++) px_q.push_back(int'($urandom % 256));
    bin_req = "R5";
    send_frame();
    read_frame("R3");

    // frame D: empty window, final pixel outside it
    win_lo = 8'd200; win_hi = 8'd10;
    px_q.delete();
    for (int i = 0; i < 20; i++) px_q.push_back(int'($urandom % 256));
    bin_req = "R5";
    send_frame();
    read_frame("R9");

    // frame E: one pixel at level 0, window off
    win_en = 1'b0;
    px_q.delete();
    px_q.push_back(0);
    bin_req = "R2";
    send_frame();
    read_frame("R3");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule